// File: doc/BRIEF.md
# Handshaked Control-Register Port Target

This block is the target end of a narrow parallel port that reaches a bank of 16-bit control registers inside a PHY. The requester drives four request strobes: capture address, capture data, write and read. It also drives one shared 16-bit input bus. An address and a write value travel over that same bus in separate phases. Each strobe is answered on a single acknowledge line through a full four-phase cycle. The requester raises the strobe, the target raises ack, the requester drops the strobe, and the target drops ack.

A register write takes three transactions: capture the address, capture the data, then commit. A read takes two: capture the address, then read. The read result appears on a 16-bit output bus at the same edge that ack rises, and it stays there until the next read completes. The port may address any value up to a configurable ceiling, 0x201F by default. Only NUM_REGS words are backed by storage, and the low bits of the address select the word. Addresses above the ceiling are still acknowledged, but they behave as empty locations.

Top module: `crp_target`

## Requirements
- R1: After reset, ack is low and the read-data output is 0x0000. The latched address and the latched data are both 0x0000. Register k of the bank holds RST_PATTERN XOR k, which is 0xC3A0 XOR k by default.
- R2: Ack rises ACK_DELAY clock edges after the edge that first samples a lone strobe high. Ack stays high while that strobe stays high. Ack falls at the first edge that samples that strobe low.
- R3: A completed capture-address transaction stores the input bus as the current register address.
- R4: A completed capture-data transaction stores the input bus as the pending write word. A completed write transaction copies the pending word into exactly one register, the one selected by the current address.
- R5: A completed read transaction puts the selected register's value on the read-data output. The output then keeps that value through every other transaction until the next read completes.
- R6: An address above MAX_ADDR is still acknowledged. A read from it returns 0x0000, and a write to it changes no register.
- R7: If more than one strobe is high at the same sampled edge, the block treats it as a protocol error. It gives no acknowledge, changes no state, and accepts nothing until it has sampled all strobes low.
- R8: A strobe that is raised while ack is high is never served. After ack falls, the block waits until all strobes are sampled low before it accepts a new request.
- R9: If a strobe is withdrawn before its ack rises, the transaction is cancelled. No ack is given and no register, latch or output changes.
- R10: An in-range address selects bank word (address mod NUM_REGS). With the default of 32 words, addresses 0x2005 and 0x0005 reach the same register, and 0x201F and 0x001F reach the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cap_addr_i | input | 1 | Request: latch the bus as the register address |
| cap_data_i | input | 1 | Request: latch the bus as the pending write word |
| wr_req_i | input | 1 | Request: commit the pending word to the addressed register |
| rd_req_i | input | 1 | Request: read the addressed register |
| din_i | input | DATA_W | Shared address/data input bus |
| ack_o | output | 1 | Common four-phase acknowledge |
| dout_o | output | DATA_W | Read data, held until the next read completes |

## Verification
On every cycle the bound checker confirms four things. Ack only ever rises after a lone strobe. Ack holds while the answered strobe holds, and it falls only once that strobe has been sampled low. The read-data output moves only at a read completion, and it is zero when that read targets an out-of-range address. The checker also confirms that colliding strobes never produce an acknowledge. Only the directed scenarios can show the rest, because those behaviours depend on register contents that the checker does not model. That covers the exact latency count, the values in the bank and both latches, the address aliasing, and the fact that a cancelled, late or colliding request leaves the bank and the latched address untouched.

// File: rtl/crp_pkg.sv
package crp_pkg;

   // strobe positions inside the internal request vector
   localparam int unsigned N_STRB   = 4;
   localparam int unsigned STB_ADDR = 0;
   localparam int unsigned STB_DATA = 1;
   localparam int unsigned STB_WR   = 2;
   localparam int unsigned STB_RD   = 3;

   typedef enum logic [1:0] {
      HS_IDLE  = 2'd0,
      HS_WAIT  = 2'd1,
      HS_ACK   = 2'd2,
      HS_BLOCK = 2'd3
   } hs_state_t;

   // power-on content of bank word idx
   function automatic logic [63:0] crp_rst_word(input logic [63:0] pattern, input int unsigned idx);
      return pattern ^ 64'(idx);
   endfunction

endpackage

// File: rtl/crp_handshake.sv
module crp_handshake
   import crp_pkg::*;
#(
   parameter int unsigned N_REQ     = 4,
   parameter int unsigned ACK_DELAY = 2
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_REQ-1:0] strb_i,
   output logic             ack_o,
   output logic             fire_o,
   output logic [N_REQ-1:0] op_o
);
   localparam int unsigned   CNT_W = $clog2(ACK_DELAY + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_DELAY);

   hs_state_t        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [N_REQ-1:0] op_q;
   logic             ack_q;

   // commit happens on the same edge that raises ack
   assign fire_o = (state_q == HS_WAIT) && (strb_i == op_q) && (cnt_q == LAST);
   assign ack_o  = ack_q;
   assign op_o   = op_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= HS_IDLE;
         cnt_q   <= '0;
         op_q    <= '0;
         ack_q   <= 1'b0;
      end else begin
         unique case (state_q)
            HS_IDLE: begin
               if (strb_i != '0) begin
                  if ($onehot(strb_i)) begin
                     op_q    <= strb_i;
                     cnt_q   <= CNT_W'(1);
                     state_q <= HS_WAIT;
                  end else begin
                     state_q <= HS_BLOCK;
                  end
               end
            end
            HS_WAIT: begin
               if (strb_i != op_q) begin
                  op_q    <= '0;
                  state_q <= (strb_i == '0) ? HS_IDLE : HS_BLOCK;
               end else if (cnt_q == LAST) begin
                  ack_q   <= 1'b1;
                  state_q <= HS_ACK;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            HS_ACK: begin
               if ((strb_i & op_q) == '0) begin
                  ack_q   <= 1'b0;
                  op_q    <= '0;
                  state_q <= (strb_i == '0) ? HS_IDLE : HS_BLOCK;
               end
            end
            HS_BLOCK: begin
               if (strb_i == '0) state_q <= HS_IDLE;
            end
            default: state_q <= HS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/crp_reg_bank.sv
module crp_reg_bank #(
   parameter int unsigned       DATA_W      = 16,
   parameter int unsigned       NUM_REGS    = 32,
   parameter logic [DATA_W-1:0] RST_PATTERN = '0
)(
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        we_i,
   input  logic [$clog2(NUM_REGS)-1:0] idx_i,
   input  logic [DATA_W-1:0]           wdata_i,
   output logic [DATA_W-1:0]           rdata_o
);
   localparam int unsigned IDX_W = $clog2(NUM_REGS);

   logic [DATA_W-1:0] word_w [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            word_q <= DATA_W'(crp_pkg::crp_rst_word(64'(RST_PATTERN), g));
         else if (we_i && (idx_i == IDX_W'(g)))
            word_q <= wdata_i;
      end
      assign word_w[g] = word_q;
   end

   assign rdata_o = word_w[idx_i];

endmodule

// File: rtl/crp_target.sv
module crp_target #(
   parameter int unsigned       DATA_W      = 16,
   parameter int unsigned       NUM_REGS    = 32,
   parameter int unsigned       MAX_ADDR    = 32'h201F,
   parameter int unsigned       ACK_DELAY   = 2,
   parameter logic [DATA_W-1:0] RST_PATTERN = 16'hC3A0
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cap_addr_i,
   input  logic              cap_data_i,
   input  logic              wr_req_i,
   input  logic              rd_req_i,
   input  logic [DATA_W-1:0] din_i,
   output logic              ack_o,
   output logic [DATA_W-1:0] dout_o
);
   import crp_pkg::*;

   localparam int unsigned IDX_W    = $clog2(NUM_REGS);
   localparam logic [63:0] ADDR_TOP = (64'd1 << DATA_W) - 64'd1;

   // elaboration-time parameter checks
   if (ACK_DELAY < 1) begin : g_bad_delay
      $error("crp_target: ACK_DELAY must be at least 1");
   end
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_depth
      $error("crp_target: NUM_REGS must be a power of two, at least 2");
   end
   if (64'(MAX_ADDR) > ADDR_TOP) begin : g_bad_max
      $error("crp_target: MAX_ADDR does not fit the bus");
   end

   logic [N_STRB-1:0] strb;
   logic [N_STRB-1:0] hs_op;
   logic              hs_fire;
   logic [DATA_W-1:0] adr_q;
   logic [DATA_W-1:0] dat_q;
   logic [DATA_W-1:0] dout_q;
   logic [DATA_W-1:0] bank_rd;
   logic              in_range;
   logic              bank_we;

   assign strb[STB_ADDR] = cap_addr_i;
   assign strb[STB_DATA] = cap_data_i;
   assign strb[STB_WR]   = wr_req_i;
   assign strb[STB_RD]   = rd_req_i;

   crp_handshake #(
      .N_REQ     (N_STRB),
      .ACK_DELAY (ACK_DELAY)
   ) u_hs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .strb_i (strb),
      .ack_o  (ack_o),
      .fire_o (hs_fire),
      .op_o   (hs_op)
   );

   // range check variant: none needed when the ceiling covers the whole bus
   if (64'(MAX_ADDR) >= ADDR_TOP) begin : g_full_range
      assign in_range = 1'b1;
   end else begin : g_cmp_range
      assign in_range = (adr_q <= DATA_W'(MAX_ADDR));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         adr_q  <= '0;
         dat_q  <= '0;
         dout_q <= '0;
      end else if (hs_fire) begin
         if (hs_op[STB_ADDR]) adr_q  <= din_i;
         if (hs_op[STB_DATA]) dat_q  <= din_i;
         if (hs_op[STB_RD])   dout_q <= in_range ? bank_rd : '0;
      end
   end

   assign bank_we = hs_fire && hs_op[STB_WR] && in_range;

   crp_reg_bank #(
      .DATA_W      (DATA_W),
      .NUM_REGS    (NUM_REGS),
      .RST_PATTERN (RST_PATTERN)
   ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we),
      .idx_i   (adr_q[IDX_W-1:0]),
      .wdata_i (dat_q),
      .rdata_o (bank_rd)
   );

   assign dout_o = dout_q;

endmodule

// File: rtl/crp_target_chk.sv
module crp_target_chk #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned MAX_ADDR = 32'h201F
)(
   input logic              clk_i,
   input logic              rst_ni,
   input logic [3:0]        strb_i,
   input logic              ack_i,
   input logic [DATA_W-1:0] dout_i,
   input logic [3:0]        op_i,
   input logic [DATA_W-1:0] adr_i
);
   localparam int unsigned RD_BIT = crp_pkg::STB_RD;

   // R2: ack only rises after a lone strobe was sampled
   assert_ack_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ack_i) |-> ($countones($past(strb_i)) == 1));

   // R2: ack holds while the answered strobe is held
   assert_ack_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && ((strb_i & op_i) != 4'b0)) |=> ack_i);

   // R2: ack falls only after the answered strobe was sampled low
   assert_ack_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ack_i) |-> ($past(strb_i & op_i) == 4'b0));

   // R5: read data moves only when a read completes
   assert_dout_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !($rose(ack_i) && op_i[RD_BIT]) |-> $stable(dout_i));

   // R6: out-of-range read returns zero
   assert_oor_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(ack_i) && op_i[RD_BIT] && (32'(adr_i) > MAX_ADDR)) |-> (dout_i == '0));

   // R7: colliding strobes never produce an acknowledge
   assert_no_ack_collide_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($countones(strb_i) > 1) && !ack_i) |=> !ack_i);

   // R2: at most one operation is ever in flight
   assert_single_op_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(op_i));

endmodule

bind crp_target crp_target_chk #(
   .DATA_W   (DATA_W),
   .MAX_ADDR (MAX_ADDR)
) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .strb_i (strb),
   .ack_i  (ack_o),
   .dout_i (dout_o),
   .op_i   (hs_op),
   .adr_i  (adr_q)
);

// File: tb/tb_crp_target.sv
module tb_crp_target;
   localparam int unsigned DW   = 16;
   localparam int unsigned NR   = 32;
   localparam int unsigned MAXA = 32'h201F;
   localparam int unsigned D    = 2;
   localparam logic [15:0] PAT  = 16'hC3A0;
   localparam int OP_ADDR = 0, OP_DATA = 1, OP_WR = 2, OP_RD = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    stb = 4'b0;
   logic [DW-1:0] din = '0;
   logic          ack;
   logic [DW-1:0] dout;

   int tests = 0;
   int fails = 0;
   int last_lat;
   bit last_fall;
   logic [15:0] last_rd;

   always #4 clk = ~clk;

   crp_target #(
      .DATA_W(DW), .NUM_REGS(NR), .MAX_ADDR(MAXA), .ACK_DELAY(D), .RST_PATTERN(PAT)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n),
      .cap_addr_i(stb[OP_ADDR]), .cap_data_i(stb[OP_DATA]),
      .wr_req_i(stb[OP_WR]), .rd_req_i(stb[OP_RD]),
      .din_i(din), .ack_o(ack), .dout_o(dout)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // one full four-phase transaction; latency counted in negedges after raise
   task automatic xact(input int which, input logic [15:0] bus);
      @(negedge clk);
      din = bus;
      stb[which] = 1'b1;
      last_lat = 0;
      for (int n = 1; n <= 20; n++) begin
         @(negedge clk);
         if (ack) begin
            last_lat = n;
            break;
         end
      end
      last_rd = dout;
      stb = 4'b0;
      @(negedge clk);
      last_fall = !ack;
   endtask

   task automatic wr_reg(input logic [15:0] a, input logic [15:0] v);
      xact(OP_ADDR, a);
      xact(OP_DATA, v);
      xact(OP_WR, 16'h0);
   endtask

   task automatic rd_reg(input logic [15:0] a, output logic [15:0] v);
      xact(OP_ADDR, a);
      xact(OP_RD, 16'h0);
      v = last_rd;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      check(ack == 1'b0, "R1", "ack after reset", 32'(ack), 0);
      check(dout == 16'h0, "R1", "dout after reset", 32'(dout), 0);
      xact(OP_RD, 16'hFFFF);   // no address captured yet: address 0
      check(last_rd == PAT, "R1", "read with reset address", 32'(last_rd), 32'(PAT));
      rd_reg(16'h0007, v);
      check(v == (PAT ^ 16'h0007), "R1", "reset word 7", 32'(v), 32'(PAT ^ 16'h0007));
      rd_reg(16'h001F, v);
      check(v == (PAT ^ 16'h001F), "R1", "reset word 31", 32'(v), 32'(PAT ^ 16'h001F));
   endtask

   task automatic t_handshake();
      bit held;
      xact(OP_ADDR, 16'h0002);
      check(last_lat == D + 1, "R2", "ack latency", 32'(last_lat), 32'(D + 1));
      check(last_fall, "R2", "ack falls after strobe low", 32'(!last_fall), 0);
      @(negedge clk);
      stb[OP_RD] = 1'b1;
      repeat (D + 1) @(negedge clk);
      held = ack;
      repeat (4) begin
         @(negedge clk);
         held = held & ack;
      end
      check(held, "R2", "ack held with strobe", 32'(held), 1);
      stb = 4'b0;
      @(negedge clk);
      check(!ack, "R2", "ack release", 32'(ack), 0);
   endtask

   task automatic t_write_read();
      logic [15:0] v;
      wr_reg(16'h0003, 16'h1234);
      rd_reg(16'h0003, v);
      check(v == 16'h1234, "R4", "write then read word 3", 32'(v), 32'h1234);
      wr_reg(16'h0010, 16'hBEEF);
      rd_reg(16'h0010, v);
      check(v == 16'hBEEF, "R3", "address capture word 16", 32'(v), 32'hBEEF);
      rd_reg(16'h0003, v);
      check(v == 16'h1234, "R4", "only one word changed", 32'(v), 32'h1234);
   endtask

   task automatic t_alias();
      logic [15:0] v;
      wr_reg(16'h2005, 16'h7777);
      rd_reg(16'h0005, v);
      check(v == 16'h7777, "R10", "0x2005 aliases 0x0005", 32'(v), 32'h7777);
      wr_reg(16'h201F, 16'h5A5A);
      check(last_lat == D + 1, "R10", "top valid address acked", 32'(last_lat), 32'(D + 1));
      rd_reg(16'h001F, v);
      check(v == 16'h5A5A, "R10", "0x201F aliases 0x001F", 32'(v), 32'h5A5A);
   endtask

   task automatic t_hold();
      logic [15:0] v;
      rd_reg(16'h0010, v);
      xact(OP_ADDR, 16'h0003);
      xact(OP_DATA, 16'h9999);
      check(dout == 16'hBEEF, "R5", "dout held across captures", 32'(dout), 32'hBEEF);
      xact(OP_WR, 16'h0);
      check(dout == 16'hBEEF, "R5", "dout held across write", 32'(dout), 32'hBEEF);
      rd_reg(16'h0003, v);
      check(v == 16'h9999, "R5", "next read updates", 32'(v), 32'h9999);
   endtask

   task automatic t_out_of_range();
      logic [15:0] v;
      wr_reg(16'h2020, 16'hFFFF);
      check(last_lat == D + 1, "R6", "oor write acked", 32'(last_lat), 32'(D + 1));
      rd_reg(16'h2020, v);
      check(last_lat == D + 1, "R6", "oor read acked", 32'(last_lat), 32'(D + 1));
      check(v == 16'h0000, "R6", "oor read value", 32'(v), 0);
      rd_reg(16'h0000, v);
      check(v == PAT, "R6", "oor write discarded", 32'(v), 32'(PAT));
      rd_reg(16'hFFFF, v);
      check(v == 16'h0000, "R6", "read 0xFFFF value", 32'(v), 0);
   endtask

   task automatic t_collide();
      bit seen = 1'b0;
      xact(OP_ADDR, 16'h0003);
      @(negedge clk);
      din = 16'h0010;
      stb[OP_ADDR] = 1'b1;
      stb[OP_DATA] = 1'b1;
      repeat (6) begin
         @(negedge clk);
         seen = seen | ack;
      end
      stb = 4'b0;
      @(negedge clk);
      check(!seen, "R7", "no ack on collision", 32'(seen), 0);
      xact(OP_RD, 16'h0);
      check(last_rd == 16'h9999, "R7", "address unchanged after collision", 32'(last_rd), 32'h9999);
   endtask

   task automatic t_late();
      bit seen = 1'b0;
      logic [15:0] v;
      xact(OP_DATA, 16'h4444);
      xact(OP_ADDR, 16'h0004);
      @(negedge clk);
      stb[OP_RD] = 1'b1;
      repeat (D + 1) @(negedge clk);
      stb[OP_WR] = 1'b1;
      @(negedge clk);
      stb[OP_RD] = 1'b0;
      @(negedge clk);
      repeat (6) begin
         @(negedge clk);
         seen = seen | ack;
      end
      stb = 4'b0;
      @(negedge clk);
      check(!seen, "R8", "late write not acked", 32'(seen), 0);
      rd_reg(16'h0004, v);
      check(v == (PAT ^ 16'h0004), "R8", "late write not committed", 32'(v), 32'(PAT ^ 16'h0004));
   endtask

   task automatic t_cancel();
      bit seen = 1'b0;
      logic [15:0] v;
      xact(OP_ADDR, 16'h0006);
      xact(OP_DATA, 16'h4242);
      @(negedge clk);
      stb[OP_WR] = 1'b1;
      @(negedge clk);
      stb = 4'b0;
      repeat (6) begin
         @(negedge clk);
         seen = seen | ack;
      end
      check(!seen, "R9", "cancelled write not acked", 32'(seen), 0);
      xact(OP_RD, 16'h0);
      v = last_rd;
      check(v == (PAT ^ 16'h0006), "R9", "cancelled write had no effect", 32'(v), 32'(PAT ^ 16'h0006));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_handshake();
      t_write_read();
      t_alias();
      t_hold();
      t_out_of_range();
      t_collide();
      t_late();
      t_cancel();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule